// File: doc/BRIEF.md
# DDR Read Burst Timing Engine

This block is the memory-side read path of a double-data-rate SDRAM model, written to be synthesized. It runs on a clock at twice the CK rate, phase-locked to CK. Command pins are sampled only on the 2x edges that match CK rising edges. `cmd_slot_o` is high in every 2x cycle whose closing edge is such a command edge. At reset the first 2x cycle is a command slot, and the slots then alternate.

An ACTIVATE command starts a per-bank row-to-column delay timer. A READ command captures the bank and the starting column. It is refused, and flagged, if it arrives too early. It is also refused and flagged if a burst is already running.

An accepted READ waits the selected CAS latency of 2 or 2.5 CK cycles. One data word is then driven on each half-cycle. The strobe goes high on even beats and low on odd beats. It is driven low for one CK cycle before the data and for half a CK cycle after it. Data comes from a computed read-only pattern: each word is the bank, a fixed nibble 0x5, and the column. Output-enable flags mark where the pins would be driven; outside those windows the pins are tri-stated.

Top module: `ddr_rd_engine`

## Requirements
- R1: A READ is taken only on a command edge with cs_n=0, ras_n=1, cas_n=0, we_n=1. Any other pin code on a command edge, including cs_n=1, starts no burst.
- R2: ACTIVATE is cs_n=0, ras_n=0, cas_n=1, we_n=1. A READ is refused if fewer than TRCD_CK (default 3) command edges separate it from the last ACTIVATE of its bank, or if that bank was never activated. A refused READ starts no burst and sets `rcd_err_o` for the single half-cycle right after the READ edge.
- R3: The first data word is driven in half-cycle 4 after the READ edge when mode bit 3 is 0 (latency 2). It is driven in half-cycle 5 when mode bit 3 is 1 (latency 2.5). Half-cycle 0 is the half that the READ edge opens.
- R4: Mode bits [1:0] give the burst length: 01 gives 2, 10 gives 4, 11 gives 8, and 00 is taken as 2. `dq_oe_o` is high for exactly that many consecutive half-cycles.
- R5: With mode bit 2 at 0 (sequential), beat i reads column (S & ~(L-1)) | ((S + i) mod L), where S is the start column and L is the burst length.
- R6: With mode bit 2 at 1 (interleaved), beat i reads column (S & ~(L-1)) | ((S mod L) XOR i).
- R7: Each data word is {bank[1:0], 4'h5, column[9:0]}. `dq_o` is zero while `dq_oe_o` is low.
- R8: During the two half-cycles just before the first word, `dqs_oe_o` is high, `dqs_o` is low and `dq_oe_o` is low.
- R9: During data, `dqs_o` is 1 on even beats (0, 2, ...) and 0 on odd beats.
- R10: In the one half-cycle after the last word, `dqs_oe_o` is high with `dqs_o` low. In the half-cycle after that, both enables are low.
- R11: A READ that arrives on a command edge while a burst is active, from its READ edge through its postamble half, is ignored. The running burst continues unchanged, and `busy_err_o` is set for the half-cycle after that edge.
- R12: Command pins are ignored on 2x edges that are not command edges. `cmd_slot_o` is 1 in reset and then alternates each 2x cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 2x clock, phase-locked to CK |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| bank_i | input | 2 | Bank address |
| addr_i | input | 10 | Start column |
| mode_i | input | 4 | [3] latency 2.5, [2] interleaved, [1:0] length code |
| cmd_slot_o | output | 1 | Next edge samples commands |
| dq_o | output | 16 | Read data |
| dq_oe_o | output | 1 | Data pins driven |
| dqs_o | output | 1 | Data strobe level |
| dqs_oe_o | output | 1 | Strobe pin driven |
| rcd_err_o | output | 1 | READ refused, too early after ACTIVATE |
| busy_err_o | output | 1 | READ refused, burst in progress |

## Verification
The hardest cases to reach are the edges of the row-to-column window. The stimulus re-activates a bank and places the READ on exactly the first, second and third command edge after it, so the accepted and the refused cases sit one CK cycle apart. The other hard case is a second READ landing inside a running burst. That READ is driven on a chosen command slot during the preamble or the data beats. Every half-cycle of the first burst is then compared with an undisturbed one. Around these cases, a sweep over both latencies, both orders, all four length codes and start columns at block edges and at the top of the column range checks every beat against column arithmetic done in the bench.

// File: rtl/ddr_rd_pkg.sv
package ddr_rd_pkg;

  // {ras_n, cas_n, we_n} with cs_n low
  typedef enum logic [2:0] {
    CMD_ACT  = 3'b011,
    CMD_READ = 3'b101
  } cmd_e;

  typedef struct packed {
    logic       cl_half;
    logic       interleave;
    logic [1:0] bl_code;
  } mode_t;

  function automatic logic [3:0] burst_len(input logic [1:0] code);
    case (code)
      2'b10:   return 4'd4;
      2'b11:   return 4'd8;
      default: return 4'd2;
    endcase
  endfunction

endpackage

// File: rtl/ddr_rd_cmd.sv
module ddr_rd_cmd
  import ddr_rd_pkg::*;
#(
  parameter int BANKS   = 4,
  parameter int TRCD_CK = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cs_n_i,
  input  logic                     ras_n_i,
  input  logic                     cas_n_i,
  input  logic                     we_n_i,
  input  logic [$clog2(BANKS)-1:0] bank_i,
  input  logic                     busy_i,
  output logic                     slot_o,
  output logic                     start_o,
  output logic                     rcd_err_o,
  output logic                     busy_err_o
);

  localparam int CNT_W = $clog2(TRCD_CK + 1);

  logic             phase_q;
  logic             is_rd, is_act;
  logic [BANKS-1:0] rdy;

  assign slot_o = ~phase_q;
  assign is_rd  = slot_o & ~cs_n_i & ({ras_n_i, cas_n_i, we_n_i} == CMD_READ);
  assign is_act = slot_o & ~cs_n_i & ({ras_n_i, cas_n_i, we_n_i} == CMD_ACT);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) phase_q <= 1'b0;
    else         phase_q <= ~phase_q;

  // per-bank CK-cycle count since activate; 0 = never activated
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else if (is_act && bank_i == b[$clog2(BANKS)-1:0]) cnt_q <= CNT_W'(1);
      else if (slot_o && cnt_q != '0 && cnt_q < CNT_W'(TRCD_CK)) cnt_q <= cnt_q + 1'b1;
    end
    assign rdy[b] = cnt_q >= CNT_W'(TRCD_CK);
  end

  assign start_o = is_rd & ~busy_i & rdy[bank_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rcd_err_o  <= 1'b0;
      busy_err_o <= 1'b0;
    end else begin
      rcd_err_o  <= is_rd & ~busy_i & ~rdy[bank_i];
      busy_err_o <= is_rd & busy_i;
    end
  end

  p_err_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rcd_err_o && busy_err_o));
  p_busy_blocks_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !start_o);
  p_rcd_no_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rcd_err_o |-> !busy_i || $past(busy_i));

endmodule

// File: rtl/ddr_rd_burst.sv
module ddr_rd_burst
  import ddr_rd_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int BANK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [BANK_W-1:0] bank_i,
  input  mode_t             mode_i,
  output logic              busy_o,
  output logic [COL_W-1:0]  col_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              dq_oe_o,
  output logic              dqs_o,
  output logic              dqs_oe_o
);

  localparam int H_W = $clog2(5 + 8 + 1);

  logic             active_q;
  logic [H_W-1:0]   h_q, cl_q, bl_q, beat;
  logic             il_q;
  logic [COL_W-1:0] start_q, mask, low;
  logic             pre_win, dat_win, post_win;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      h_q      <= '0;
      cl_q     <= H_W'(4);
      bl_q     <= H_W'(2);
      il_q     <= 1'b0;
      start_q  <= '0;
      bank_o   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      h_q      <= '0;
      cl_q     <= mode_i.cl_half ? H_W'(5) : H_W'(4);
      bl_q     <= H_W'(burst_len(mode_i.bl_code));
      il_q     <= mode_i.interleave;
      start_q  <= col_i;
      bank_o   <= bank_i;
    end else if (active_q) begin
      if (h_q == cl_q + bl_q) active_q <= 1'b0;
      else                    h_q      <= h_q + 1'b1;
    end
  end

  assign busy_o   = active_q;
  assign pre_win  = active_q && h_q >= cl_q - H_W'(2) && h_q < cl_q;
  assign dat_win  = active_q && h_q >= cl_q && h_q < cl_q + bl_q;
  assign post_win = active_q && h_q == cl_q + bl_q;

  assign beat = h_q - cl_q;
  assign mask = COL_W'(bl_q) - 1'b1;
  assign low  = il_q ? ((start_q ^ COL_W'(beat)) & mask)
                     : ((start_q + COL_W'(beat)) & mask);
  assign col_o = (start_q & ~mask) | low;

  assign dq_oe_o  = dat_win;
  assign dqs_o    = dat_win & ~beat[0];
  assign dqs_oe_o = pre_win | dat_win | post_win;

  p_dq_in_dqs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> dqs_oe_o);
  p_preamble_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dqs_oe_o) |-> !dqs_o && !dq_oe_o);
  p_toggle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o && $past(dq_oe_o) |-> dqs_o != $past(dqs_o));
  p_postamble_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dq_oe_o) |-> dqs_oe_o && !dqs_o);
  p_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dqs_oe_o) |-> $past(!dq_oe_o && !dqs_o));

endmodule

// File: rtl/ddr_rd_engine.sv
module ddr_rd_engine
  import ddr_rd_pkg::*;
#(
  parameter int BANKS   = 4,
  parameter int COL_W   = 10,
  parameter int TRCD_CK = 3,
  localparam int BANK_W = $clog2(BANKS),
  localparam int DQ_W   = BANK_W + 4 + COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              ras_n_i,
  input  logic              cas_n_i,
  input  logic              we_n_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  addr_i,
  input  logic [3:0]        mode_i,
  output logic              cmd_slot_o,
  output logic [DQ_W-1:0]   dq_o,
  output logic              dq_oe_o,
  output logic              dqs_o,
  output logic              dqs_oe_o,
  output logic              rcd_err_o,
  output logic              busy_err_o
);

  logic              start, busy;
  logic [COL_W-1:0]  col;
  logic [BANK_W-1:0] bank_q;

  ddr_rd_cmd #(.BANKS(BANKS), .TRCD_CK(TRCD_CK)) u_cmd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_n_i     (cs_n_i),
    .ras_n_i    (ras_n_i),
    .cas_n_i    (cas_n_i),
    .we_n_i     (we_n_i),
    .bank_i     (bank_i),
    .busy_i     (busy),
    .slot_o     (cmd_slot_o),
    .start_o    (start),
    .rcd_err_o  (rcd_err_o),
    .busy_err_o (busy_err_o)
  );

  ddr_rd_burst #(.COL_W(COL_W), .BANK_W(BANK_W)) u_burst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .col_i    (addr_i),
    .bank_i   (bank_i),
    .mode_i   (mode_t'(mode_i)),
    .busy_o   (busy),
    .col_o    (col),
    .bank_o   (bank_q),
    .dq_oe_o  (dq_oe_o),
    .dqs_o    (dqs_o),
    .dqs_oe_o (dqs_oe_o)
  );

  // computed read-only pattern array
  assign dq_o = dq_oe_o ? {bank_q, 4'h5, col} : '0;

  p_dq_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dq_oe_o |-> dq_o == '0);
  p_start_slot_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(cmd_slot_o));

endmodule

// File: tb/ddr_rd_engine_tb.sv
module ddr_rd_engine_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        cs_n, ras_n, cas_n, we_n;
  logic [1:0]  bank;
  logic [9:0]  addr;
  logic [3:0]  mode;
  logic        cmd_slot, dq_oe, dqs, dqs_oe, rcd_err, busy_err;
  logic [15:0] dq;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ddr_rd_engine u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .cs_n_i     (cs_n),
    .ras_n_i    (ras_n),
    .cas_n_i    (cas_n),
    .we_n_i     (we_n),
    .bank_i     (bank),
    .addr_i     (addr),
    .mode_i     (mode),
    .cmd_slot_o (cmd_slot),
    .dq_o       (dq),
    .dq_oe_o    (dq_oe),
    .dqs_o      (dqs),
    .dqs_oe_o   (dqs_oe),
    .rcd_err_o  (rcd_err),
    .busy_err_o (busy_err)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [20:0] obs();
    return {dq_oe, dqs_oe, dqs, rcd_err, busy_err, dq};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [20:0] act, input logic [20:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic c, r, a, w, input logic [1:0] b, input logic [9:0] col);
    cs_n = c; ras_n = r; cas_n = a; we_n = w; bank = b; addr = col;
  endtask

  task automatic nop();
    drive(1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 10'd0);
  endtask

  task automatic wait_slot();
    do @(negedge clk); while (!cmd_slot);
  endtask

  task automatic activate(input logic [1:0] b);
    wait_slot();
    drive(1'b0, 1'b0, 1'b1, 1'b1, b, 10'd0);
    @(negedge clk);
    nop();
  endtask

  function automatic logic [9:0] exp_col(input int s, input int bl, input bit il, input int i);
    int lo;
    lo = il ? ((s % bl) ^ i) : (((s % bl) + i) % bl);
    return 10'((s / bl) * bl + lo);
  endfunction

  task automatic idle_check(input int halves, input string tag);
    for (int n = 0; n < halves; n++) begin
      @(negedge clk);
      chk(obs() == '0, tag, obs(), '0);
    end
  endtask

  task automatic do_burst(input int nslots, input logic [1:0] b, input logic [9:0] col,
                          input logic [3:0] md, input int inject, input bit exp_rcd);
    int cl, bl;
    bit il;
    cl = md[3] ? 5 : 4;
    bl = (md[1:0] == 2'b10) ? 4 : (md[1:0] == 2'b11) ? 8 : 2;
    il = md[2];
    mode = md;
    repeat (nslots) wait_slot();
    drive(1'b0, 1'b1, 1'b0, 1'b1, b, col);
    for (int n = 0; n < cl + bl + 3; n++) begin
      bit pre, dat, post, e_dqs;
      logic [15:0] e_dq;
      logic [20:0] e;
      string tag;
      @(negedge clk);
      pre   = !exp_rcd && n >= cl - 2 && n < cl;
      dat   = !exp_rcd && n >= cl && n < cl + bl;
      post  = !exp_rcd && n == cl + bl;
      e_dqs = dat && ((n - cl) % 2 == 0);
      e_dq  = dat ? {b, 4'h5, exp_col(int'(col), bl, il, n - cl)} : 16'h0;
      e     = {dat, pre | dat | post, e_dqs, exp_rcd && n == 0,
               inject >= 0 && n == inject + 1, e_dq};
      if (exp_rcd)                         tag = "R2 refused read";
      else if (inject >= 0 && n == inject + 1) tag = "R11 busy flag";
      else if (pre)                        tag = "R8 preamble";
      else if (dat)                        tag = il ? "R6 interleaved beat (R3 R4 R7 R9)"
                                                    : "R5 sequential beat (R3 R4 R7 R9)";
      else if (post)                       tag = "R10 postamble";
      else                                 tag = "R3 R10 idle window";
      chk(obs() == e, tag, obs(), e);
      if (n == inject) drive(1'b0, 1'b1, 1'b0, 1'b1, 2'd1, 10'd77);
      else             nop();
    end
  endtask

  initial begin
    int starts[7] = '{0, 3, 6, 7, 517, 1021, 1023};
    rst_ni = 1'b0;
    mode   = 4'b0;
    nop();
    repeat (3) @(negedge clk);
    chk(obs() == '0 && cmd_slot, "R12 reset state", {cmd_slot, obs()[19:0]}, {1'b1, 20'h0});
    rst_ni = 1'b1;

    for (int b = 0; b < 3; b++) activate(2'(b));
    repeat (8) @(negedge clk);

    // sweep latency x order x length code x start column
    for (int c = 0; c < 2; c++)
      for (int t = 0; t < 2; t++)
        for (int l = 0; l < 4; l++)
          for (int s = 0; s < 7; s++)
            do_burst(1, 2'((s + l) % 3), 10'(starts[s]), {1'(c), 1'(t), 2'(l)}, -1, 1'b0);

    // R2: READ one, two and three CK cycles after ACTIVATE
    activate(2'd2);
    do_burst(1, 2'd2, 10'd9, 4'b0110, -1, 1'b1);
    activate(2'd2);
    do_burst(2, 2'd2, 10'd9, 4'b0110, -1, 1'b1);
    activate(2'd2);
    do_burst(3, 2'd2, 10'd9, 4'b0110, -1, 1'b0);
    // R2: bank 3 never activated
    do_burst(1, 2'd3, 10'd4, 4'b0010, -1, 1'b1);

    // R11: READ during preamble wait and during data beats
    do_burst(1, 2'd0, 10'd13, 4'b1011, 1, 1'b0);
    do_burst(1, 2'd1, 10'd250, 4'b0111, 5, 1'b0);
    do_burst(1, 2'd0, 10'd2, 4'b1110, 7, 1'b0);

    // R12: READ presented only on a non-command edge
    wait_slot();
    @(negedge clk);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 10'd5);
    @(negedge clk);
    nop();
    idle_check(14, "R12 off-slot read ignored");

    // R1: deselected read, write code, refresh-like code
    wait_slot(); drive(1'b1, 1'b1, 1'b0, 1'b1, 2'd0, 10'd5);
    @(negedge clk); nop(); idle_check(14, "R1 deselected read");
    wait_slot(); drive(1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 10'd5);
    @(negedge clk); nop(); idle_check(14, "R1 write code");
    wait_slot(); drive(1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 10'd5);
    @(negedge clk); nop(); idle_check(14, "R1 other code");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule